// File: doc/BRIEF.md
# Mode-configurable fractional 16x16 multiplier

This block is the product stage of a multiply-accumulate datapath. Each of its two 32-bit source words holds two 16-bit halves. One half-select bit per operand chooses which half is used. The two chosen halves are multiplied. A 4-bit mode code sets three things: whether the halves are treated as signed or unsigned, whether the product gets the one-bit left shift that fractional (Q15) arithmetic needs, and whether the 32-bit result is sign- or zero-extended to 64 bits. A mixed flag overrides the operand treatment so that the first half is signed and the second is unsigned.

The result is registered. It appears with an output strobe one cycle after an input strobe. The extended 64-bit product is ready for a later accumulate or extract stage. In the fractional modes, the single product that would overflow (minus one times minus one) is clamped to the largest positive 32-bit value. A mode code outside the defined set is flagged and yields a zero product.

Top module: `frac_mul16`

## Requirements
- R1: The half-select bit of each operand picks bits [31:16] when it is 1 and bits [15:0] when it is 0.
- R2: In mode codes 0, 2, 4, 6, 7 and 8, with the mixed flag clear, both selected halves are sign-extended before multiplying.
- R3: In mode codes 1, 3 and 5, with the mixed flag clear, both selected halves are zero-extended before multiplying.
- R4: When the mixed flag is 1, the first half is sign-extended and the second half is zero-extended, in every legal mode.
- R5: In mode codes 0, 4 and 6, the 32-bit product (taken modulo 2^32) is shifted left by one bit. In every other legal mode it is not shifted.
- R6: In mode codes 0, 4 and 6, a raw 32-bit product of 0x40000000 gives 0x7FFFFFFF instead of the shifted value.
- R7: The 32-bit result is sign-extended to 64 bits in mode codes 0, 2, 4, 6, 7 and 8, and zero-extended in codes 1, 3 and 5, whatever the mixed flag is.
- R8: A mode code above 8 sets the illegal output to 1 and makes the product 0. A legal code sets illegal to 0.
- R9: After reset, out_valid, product and illegal are 0. out_valid is 1 exactly in the cycle after a cycle with in_valid 1. The product and illegal outputs hold their values while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; operands are captured on this cycle |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| sel_a_hi | input | 1 | 1 selects the upper half of src_a |
| sel_b_hi | input | 1 | 1 selects the upper half of src_b |
| mode | input | 4 | Mode code 0..8 (see R2, R3, R5, R7) |
| mixed | input | 1 | 1 makes the first half signed and the second unsigned |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| product | output | 64 | Extended product |
| illegal | output | 1 | 1 when the captured mode code was undefined |

## Verification
The bench goes after the fractional clamp. With -1 times -1, a design that shifted without checking would return 0x80000000, which extends to a negative 64-bit value. The same inputs in an integer mode must not be clamped. A mixed-flag case with both halves 0xFFFF separates the three operand treatments: signed gives 1, unsigned gives 0xFFFE0001, and mixed gives 0xFFFF0001. Running it in an unsigned mode also shows whether the mixed flag was wrongly allowed to change the extension. Further checks cover undefined mode codes that leave a stale or non-zero product, idle cycles where the product must not move, and a long run of random operands checked against a behavioural model.

// File: rtl/frac_mul16.sv
module frac_mul16 #(
  parameter int HALF_W = 16,
  parameter int MODE_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2*HALF_W-1:0]   src_a,
  input  logic [2*HALF_W-1:0]   src_b,
  input  logic                  sel_a_hi,
  input  logic                  sel_b_hi,
  input  logic [MODE_W-1:0]     mode,
  input  logic                  mixed,
  output logic                  out_valid,
  output logic [4*HALF_W-1:0]   product,
  output logic                  illegal
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int PROD_W = 4 * HALF_W;

  localparam logic [MODE_W-1:0] MD_FRAC    = MODE_W'(0);
  localparam logic [MODE_W-1:0] MD_FRAC_U  = MODE_W'(1);
  localparam logic [MODE_W-1:0] MD_INT_S   = MODE_W'(2);
  localparam logic [MODE_W-1:0] MD_INT_U   = MODE_W'(3);
  localparam logic [MODE_W-1:0] MD_TRUNC   = MODE_W'(4);
  localparam logic [MODE_W-1:0] MD_TRUNC_U = MODE_W'(5);
  localparam logic [MODE_W-1:0] MD_RND2    = MODE_W'(6);
  localparam logic [MODE_W-1:0] MD_INT_S2  = MODE_W'(7);
  localparam logic [MODE_W-1:0] MD_INT_HI  = MODE_W'(8);

  localparam logic [WORD_W-1:0] OVF_RAW = WORD_W'(1) << (WORD_W - 2);
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};

  logic              sgn_mode, frac_mode, sext_mode, bad_mode;
  logic [HALF_W-1:0] half_a, half_b;
  logic              ext_a, ext_b;
  logic [WORD_W-1:0] wide_a, wide_b, raw, adj;
  logic [PROD_W-1:0] ext_prod;

  always_comb begin
    sgn_mode  = 1'b0;
    frac_mode = 1'b0;
    sext_mode = 1'b0;
    bad_mode  = 1'b0;
    case (mode)
      MD_FRAC, MD_TRUNC, MD_RND2: begin
        sgn_mode  = 1'b1;
        frac_mode = 1'b1;
        sext_mode = 1'b1;
      end
      MD_INT_S, MD_INT_S2, MD_INT_HI: begin
        sgn_mode  = 1'b1;
        sext_mode = 1'b1;
      end
      MD_FRAC_U, MD_INT_U, MD_TRUNC_U: ;
      default: bad_mode = 1'b1;
    endcase
  end

  assign half_a = sel_a_hi ? src_a[WORD_W-1 -: HALF_W] : src_a[HALF_W-1:0];
  assign half_b = sel_b_hi ? src_b[WORD_W-1 -: HALF_W] : src_b[HALF_W-1:0];

  assign ext_a = (sgn_mode | mixed) & half_a[HALF_W-1];
  assign ext_b = (sgn_mode & ~mixed) & half_b[HALF_W-1];

  assign wide_a = {{HALF_W{ext_a}}, half_a};
  assign wide_b = {{HALF_W{ext_b}}, half_b};
  assign raw    = wide_a * wide_b;

  assign adj = !frac_mode       ? raw :
               (raw == OVF_RAW) ? POS_MAX : (raw << 1);

  assign ext_prod = bad_mode  ? '0 :
                    sext_mode ? {{WORD_W{adj[WORD_W-1]}}, adj} :
                                {{WORD_W{1'b0}}, adj};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        product <= ext_prod;
        illegal <= bad_mode;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(product) && $stable(illegal))); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> (product == '0)); // R8
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(mode) == MD_FRAC_U || $past(mode) == MD_INT_U || $past(mode) == MD_TRUNC_U))
      |-> (product[PROD_W-1:WORD_W] == '0)); // R7
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal) |-> (product[PROD_W-1:WORD_W] == '0 || product[PROD_W-1:WORD_W] == '1)); // R7
  AST_FRAC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(mode) == MD_FRAC || $past(mode) == MD_TRUNC || $past(mode) == MD_RND2)
      && product[WORD_W-1:0] != POS_MAX) |-> !product[0]); // R5

endmodule

// File: tb/sim_frac_mul16.sv
module sim_frac_mul16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        sel_a_hi = 1'b0, sel_b_hi = 1'b0, mixed = 1'b0;
  logic [3:0]  mode = '0;
  logic        out_valid, illegal;
  logic [63:0] product;

  int checks = 0;
  int failures = 0;
  logic [63:0] last_p = '0;
  logic        last_i = 1'b0;

  always #10 clk = ~clk;

  frac_mul16 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .sel_a_hi(sel_a_hi), .sel_b_hi(sel_b_hi),
    .mode(mode), .mixed(mixed),
    .out_valid(out_valid), .product(product), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refm(input logic [31:0] a, input logic [31:0] b,
                               input logic sa, input logic sb, input logic [3:0] md,
                               input logic mx, output logic [63:0] p, output logic ill);
    logic [15:0] ha, hb;
    longint xa, xb, pr;
    logic [63:0] t;
    logic [31:0] r;
    bit sgn, frac;
    ha = sa ? a[31:16] : a[15:0];
    hb = sb ? b[31:16] : b[15:0];
    sgn  = (md == 0 || md == 2 || md == 4 || md == 6 || md == 7 || md == 8);
    frac = (md == 0 || md == 4 || md == 6);
    if (md > 8) begin
      p = '0;
      ill = 1'b1;
      return;
    end
    ill = 1'b0;
    xa = (sgn || mx) ? longint'($signed(ha)) : longint'({48'b0, ha});
    xb = (sgn && !mx) ? longint'($signed(hb)) : longint'({48'b0, hb});
    pr = xa * xb;
    t = pr;
    r = t[31:0];
    if (frac) r = (r == 32'h4000_0000) ? 32'h7FFF_FFFF : (r << 1);
    p = sgn ? {{32{r[31]}}, r} : {32'b0, r};
  endfunction

  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic sa, input logic sb,
                    input logic [3:0] md, input logic mx, input string tag);
    logic [63:0] ep;
    logic        ei;
    refm(a, b, sa, sb, md, mx, ep, ei);
    src_a = a; src_b = b; sel_a_hi = sa; sel_b_hi = sb; mode = md; mixed = mx;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", {63'b0, out_valid}, 64'd1);
    chk(product == ep, tag, product, ep);
    chk(illegal == ei, tag, {63'b0, illegal}, {63'b0, ei});
    last_p = ep;
    last_i = ei;
  endtask

  task automatic idle(input logic [31:0] a, input logic [3:0] md);
    in_valid = 1'b0;
    src_a = a; src_b = ~a; mode = md; sel_a_hi = ~sel_a_hi;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", {63'b0, out_valid}, 64'd0);
    chk(product == last_p, "R9", product, last_p);
    chk(illegal == last_i, "R9", {63'b0, illegal}, {63'b0, last_i});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", {63'b0, out_valid}, 64'd0);
    chk(product == 64'd0, "R9", product, 64'd0);
    chk(illegal == 1'b0, "R9", {63'b0, illegal}, 64'd0);
    rst_n = 1'b1;

    op(32'h1234_0003, 32'h0005_0002, 0, 0, 4'd2, 0, "R1");
    op(32'h1234_0003, 32'h0005_0002, 1, 0, 4'd2, 0, "R1");
    op(32'h1234_0003, 32'h0005_0002, 0, 1, 4'd2, 0, "R1");
    op(32'h1234_0003, 32'h0005_0002, 1, 1, 4'd2, 0, "R1");

    op(32'h0000_FFFF, 32'h0000_0003, 0, 0, 4'd2, 0, "R2");
    op(32'hFFFF_0000, 32'hFFFF_0000, 1, 1, 4'd8, 0, "R2");
    op(32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 4'd3, 0, "R3");
    op(32'h0000_8000, 32'h0000_FFFF, 0, 0, 4'd5, 0, "R3");

    op(32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 4'd3, 1, "R4");
    op(32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 4'd2, 1, "R4");
    op(32'h0000_8000, 32'hFFFF_0000, 0, 1, 4'd0, 1, "R4");

    op(32'h0000_4000, 32'h0000_4000, 0, 0, 4'd0, 0, "R5");
    op(32'h0000_8000, 32'h0000_4000, 0, 0, 4'd4, 0, "R5");
    op(32'h0000_4000, 32'h0000_4000, 0, 0, 4'd7, 0, "R5");

    op(32'h0000_8000, 32'h0000_8000, 0, 0, 4'd0, 0, "R6");
    op(32'h8000_0000, 32'h0000_8000, 1, 0, 4'd4, 0, "R6");
    op(32'h0000_8000, 32'h8000_0000, 0, 1, 4'd6, 0, "R6");
    op(32'h0000_8000, 32'h0000_8000, 0, 0, 4'd2, 0, "R6");

    op(32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 4'd1, 0, "R7");
    op(32'h0000_8000, 32'h0000_8000, 0, 0, 4'd1, 0, "R7");
    op(32'h0000_FFFF, 32'h0000_0002, 0, 0, 4'd7, 0, "R7");

    op(32'h0000_0003, 32'h0000_0005, 0, 0, 4'd9, 0, "R8");
    idle(32'hDEAD_BEEF, 4'd2);
    op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 4'd15, 1, "R8");
    op(32'h0000_0003, 32'h0000_0005, 0, 0, 4'd2, 0, "R8");
    idle(32'h0000_7777, 4'd12);
    idle(32'h5555_AAAA, 4'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      logic [3:0]  rm;
      ra = $urandom;
      rb = $urandom;
      rm = 4'($urandom_range(0, 10));
      if (i % 7 == 3) idle(ra, rm);
      else op(ra, rb, ra[5], rb[9], rm, 1'($urandom_range(0, 1)), "R7");
    end

    in_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule